// File: doc/BRIEF.md
# Status-Tagged Receive Queue for a 9-Bit Serial Port

This block is the receive-side buffer of a multidrop asynchronous serial port that carries a ninth address bit with each character. The receive shift logic hands it one character at a time, together with a parity-error flag, a framing-error flag, a break flag and the address bit. The block stores all of these as a single entry. The processor sees an entry's error flags only when that entry reaches the read side, so software always knows which byte an error belongs to. The tagging works the same way when the queue is enabled (sixteen entries) and when it is disabled (one holding entry).

An overrun is handled in two ways at once. The overrun flag is written into the stored entry where the overrun happened, and it reaches software in order with the data. The overrun interrupt does not use the queue at all: it is raised in the same cycle as the event. The address bit reaches software in one of two ways. In extended-read mode it appears in the upper byte of the read word, and reading the entry also copies it into a status bit. In the other mode it goes only to a status bit, which stays set until software clears it.

Top module: `rx_tag_fifo`

## Requirements
- R1: Entries leave in the order they were accepted. While the queue is not empty, `rd_data[7:0]`, `rd_perr`, `rd_ferr`, `rd_brk` and `rd_ovr` show the oldest entry's data and flags, all taken from the same entry.
- R2: With `fifo_en`=1 the queue holds 16 entries. With `fifo_en`=0 it holds 1 entry and tags it in the same way. `rx_full` is 1 when the entry count equals the capacity.
- R3: A character that arrives while the queue is full is discarded and the entry count does not change. The overrun flag is set on the newest stored entry, provided no read happens in that same cycle.
- R4: If `ovr_pulse` is high in a cycle where a character is accepted, that character is stored with its overrun flag set. Otherwise `ovr_pulse` sets the overrun flag of the newest stored entry. When the queue is empty and nothing is written, `ovr_pulse` changes no stored entry.
- R5: `ovr_irq` is high in the same cycle as an overrun event (`ovr_pulse`, or a character discarded under R3) when `ovr_irq_en`=1. It is low when `ovr_irq_en`=0.
- R6: With `ext_read`=1, `rd_data[8]` is the head entry's address bit and `rd_data[15:9]` is zero. A read (`rd_en` with data present) loads `stat_addr` with that entry's address bit on the next cycle.
- R7: With `ext_read`=0, `rd_data[15:8]` is zero. Reading an entry whose address bit is 1 sets `stat_addr`. Once set, `stat_addr` stays set until a cycle in which `addr_clr` is high and no such read occurs.
- R8: `flush` empties the queue in one clock. It overrides any read or write in the same cycle.
- R9: After reset the queue is empty and `stat_addr`=0. While the queue is empty, `rx_avail`=0 and `rd_data` and all `rd_*` flags are 0.
- R10: `rd_en` on an empty queue has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single holding entry |
| ext_read | input | 1 | Extended-read mode select |
| flush | input | 1 | Empty the queue |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | 8 | Received character |
| rx_addr | input | 1 | Received ninth (address) bit |
| rx_perr | input | 1 | Parity error of the character |
| rx_ferr | input | 1 | Framing error of the character |
| rx_brk | input | 1 | Break detected with the character |
| ovr_pulse | input | 1 | Overrun event from the shift logic |
| ovr_irq_en | input | 1 | Overrun interrupt enable |
| rd_en | input | 1 | Pop the head entry |
| addr_clr | input | 1 | Clear the address status bit |
| rd_data | output | 16 | Head data; bit 8 holds the address bit in extended mode |
| rd_perr | output | 1 | Head parity error |
| rd_ferr | output | 1 | Head framing error |
| rd_brk | output | 1 | Head break flag |
| rd_ovr | output | 1 | Head overrun flag |
| rx_avail | output | 1 | Queue not empty (receive interrupt) |
| rx_full | output | 1 | Queue at capacity |
| stat_addr | output | 1 | Address-bit status |
| ovr_irq | output | 1 | Immediate overrun interrupt |

## Verification
The bench fills the queue to 16 entries and then pushes one more character. A design that overwrote an entry or let the count grow would return a 17th character, and a design that tagged the wrong slot would show the overrun flag on an earlier byte. The bench runs the same overflow with the queue disabled, sends an overrun pulse with and without a write in the same cycle, and reads while empty. A design that lost the flag would show no overrun where one is expected, and a design that popped on an empty read would report phantom data. It checks `ovr_irq` in the event cycle itself, which catches a registered (late) interrupt. It also drives address-bit sequences in both read modes, which catches a status bit that fails to stay set in one mode or fails to follow each read in the other.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int DATA_W = 8;
    localparam int RD_W   = 2 * DATA_W;

    typedef struct packed {
        logic              ovr;
        logic              brk;
        logic              ferr;
        logic              perr;
        logic              addr;
        logic [DATA_W-1:0] data;
    } rxf_entry_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl #(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          flush,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic          drop,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] rd_ptr,
    output logic [PW-1:0] last_ptr,
    output logic          empty,
    output logic          full
);
    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [CW-1:0] cap;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        cap      = fifo_en ? CW'(DEPTH) : CW'(1);
        empty    = (st_q.cnt == '0);
        full     = (st_q.cnt >= cap);
        rd_ok    = rd_req & ~empty & ~flush;
        wr_ok    = wr_req & ~full & ~flush;
        drop     = wr_req & full & ~flush;
        wr_ptr   = st_q.wr;
        rd_ptr   = st_q.rd;
        last_ptr = (st_q.wr == '0) ? PW'(DEPTH - 1) : st_q.wr - 1'b1;
        st_d     = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (wr_ok) st_d.wr = bump(st_q.wr);
            if (rd_ok) st_d.rd = bump(st_q.rd);
            case ({wr_ok, rd_ok})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_drop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !rd_ok) |=> (st_q.cnt == $past(st_q.cnt)));
    p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
    p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_req && !wr_req) |=> empty);
    p_cap_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (st_q.cnt <= CW'(DEPTH)));
endmodule

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  rxf_entry_t    wr_entry,
    input  logic          tag_en,
    input  logic [PW-1:0] tag_ptr,
    input  logic [PW-1:0] rd_ptr,
    output rxf_entry_t    rd_entry
);
    rxf_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)  mem_q[wr_ptr]     <= wr_entry;
        if (tag_en) mem_q[tag_ptr].ovr <= 1'b1;
    end

    always_comb rd_entry = mem_q[rd_ptr];

    p_tag_or_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && tag_en));
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fifo_en,
    input  logic            ext_read,
    input  logic            flush,
    input  logic            rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic            rx_addr,
    input  logic            rx_perr,
    input  logic            rx_ferr,
    input  logic            rx_brk,
    input  logic            ovr_pulse,
    input  logic            ovr_irq_en,
    input  logic            rd_en,
    input  logic            addr_clr,
    output logic [RD_W-1:0] rd_data,
    output logic            rd_perr,
    output logic            rd_ferr,
    output logic            rd_brk,
    output logic            rd_ovr,
    output logic            rx_avail,
    output logic            rx_full,
    output logic            stat_addr,
    output logic            ovr_irq
);
    typedef struct packed {
        logic stat_addr;
    } top_state_t;

    top_state_t st_d, st_q;
    logic          wr_ok, rd_ok, drop, empty, full, tag_en, ovr_evt;
    logic [PW-1:0] wr_ptr, rd_ptr, last_ptr;
    rxf_entry_t    wr_entry, head;

    rxf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .flush(flush),
        .wr_req(rx_valid), .rd_req(rd_en), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .drop(drop), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .last_ptr(last_ptr),
        .empty(empty), .full(full)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_ptr(wr_ptr),
        .wr_entry(wr_entry), .tag_en(tag_en), .tag_ptr(last_ptr),
        .rd_ptr(rd_ptr), .rd_entry(head)
    );

    always_comb begin
        wr_entry = '{ovr: ovr_pulse, brk: rx_brk, ferr: rx_ferr,
                     perr: rx_perr, addr: rx_addr, data: rx_data};
        ovr_evt  = ovr_pulse | drop;
        tag_en   = ovr_evt & ~wr_ok & ~empty & ~flush;
        ovr_irq  = ovr_irq_en & ovr_evt;
        rx_avail = ~empty;
        rx_full  = full;
        rd_data  = '0;
        if (!empty) rd_data = {{(DATA_W-1){1'b0}}, ext_read & head.addr, head.data};
        rd_perr  = ~empty & head.perr;
        rd_ferr  = ~empty & head.ferr;
        rd_brk   = ~empty & head.brk;
        rd_ovr   = ~empty & head.ovr;
        st_d     = st_q;
        if (ext_read) begin
            if (rd_ok)         st_d.stat_addr = head.addr;
            else if (addr_clr) st_d.stat_addr = 1'b0;
        end else begin
            if (rd_ok && head.addr) st_d.stat_addr = 1'b1;
            else if (addr_clr)      st_d.stat_addr = 1'b0;
        end
        stat_addr = st_q.stat_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_irq_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_full && !flush && ovr_irq_en) |-> ovr_irq);
    p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ovr_irq_en |-> !ovr_irq);
    p_ext_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_read && rd_en && rx_avail && !flush) |=> (stat_addr == $past(rd_data[DATA_W])));
    p_sticky_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_read && stat_addr && !addr_clr) |=> stat_addr);
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail |-> (rd_data == '0 && !rd_ovr && !rd_perr && !rd_ferr && !rd_brk));
endmodule

// File: tb/rx_tag_fifo_test.sv
module rx_tag_fifo_test;
    localparam int CLK_P = 10;

    logic clk = 0, rst_n = 0;
    logic fifo_en = 1, ext_read = 0, flush = 0, rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic rx_addr = 0, rx_perr = 0, rx_ferr = 0, rx_brk = 0;
    logic ovr_pulse = 0, ovr_irq_en = 0, rd_en = 0, addr_clr = 0;
    logic [15:0] rd_data;
    logic rd_perr, rd_ferr, rd_brk, rd_ovr, rx_avail, rx_full, stat_addr, ovr_irq;

    int total = 0, fails = 0;
    logic [12:0] q[$];
    logic m_stat = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    rx_tag_fifo uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .ext_read(ext_read),
        .flush(flush), .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr(rx_addr),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .ovr_pulse(ovr_pulse),
        .ovr_irq_en(ovr_irq_en), .rd_en(rd_en), .addr_clr(addr_clr),
        .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
        .rd_ovr(rd_ovr), .rx_avail(rx_avail), .rx_full(rx_full),
        .stat_addr(stat_addr), .ovr_irq(ovr_irq)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
        end
    endtask

    function automatic int cap_now();
        return fifo_en ? 16 : 1;
    endfunction

    function automatic logic [15:0] exp_data(input logic [12:0] e, input logic ext);
        return {7'b0, ext & e[8], e[7:0]};
    endfunction

    task automatic cyc(input logic v, input logic [7:0] d, input logic a, input logic pe,
                       input logic fe, input logic bk, input logic ovp, input logic rd,
                       input logic fl, input logic clr);
        logic full, emp, rd_ok, wr_ok, drop;
        logic [12:0] head;
        @(negedge clk);
        rx_valid = v; rx_data = d; rx_addr = a; rx_perr = pe; rx_ferr = fe;
        rx_brk = bk; ovr_pulse = ovp; rd_en = rd; flush = fl; addr_clr = clr;
        #1;
        emp  = (q.size() == 0);
        full = (q.size() >= cap_now());
        head = emp ? 13'h0 : q[0];
        chk("R9 avail", 32'(rx_avail), 32'(!emp));
        chk("R2 full", 32'(rx_full), 32'(full));
        chk(ext_read ? "R6 data" : "R7 data", 32'(rd_data), emp ? 32'h0 : 32'(exp_data(head, ext_read)));
        chk("R1 flags", 32'({rd_ovr, rd_brk, rd_ferr, rd_perr}), 32'(head[12:9]));
        drop = v && full && !fl;
        chk("R5 irq", 32'(ovr_irq), 32'(ovr_irq_en && (ovp || drop)));
        chk(ext_read ? "R6 stat" : "R7 stat", 32'(stat_addr), 32'(m_stat));
        @(posedge clk);
        rd_ok = rd && !emp && !fl;
        wr_ok = v && !full && !fl;
        if (fl) q.delete();
        else begin
            if ((ovp || drop) && !wr_ok && !emp) q[q.size()-1][12] = 1'b1;
            if (rd_ok) void'(q.pop_front());
            if (wr_ok) q.push_back({ovp, bk, fe, pe, a, d});
        end
        if (ext_read) begin
            if (rd_ok) m_stat = head[8];
            else if (clr) m_stat = 0;
        end else begin
            if (rd_ok && head[8]) m_stat = 1;
            else if (clr) m_stat = 0;
        end
        #1;
        rx_valid = 0; ovr_pulse = 0; rd_en = 0; flush = 0; addr_clr = 0;
    endtask

    task automatic put(input logic [7:0] d, input logic a);
        cyc(1, d, a, d[0], d[1], d[2], 0, 0, 0, 0);
    endtask
    task automatic take();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4242);
        #(CLK_P * 3);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R9 reset avail", 32'(rx_avail), 0);
        chk("R9 reset stat", 32'(stat_addr), 0);
        chk("R9 reset data", 32'(rd_data), 0);

        // R3: fill 16, overflow write with interrupt enabled
        fifo_en = 1; ovr_irq_en = 1;
        for (int i = 0; i < 16; i++) put(8'(i * 7 + 1), i[0]);
        chk("R2 full at 16", 32'(rx_full), 1);
        put(8'hEE, 1);
        for (int i = 0; i < 15; i++) take();
        @(negedge clk); #1;
        chk("R3 newest tagged", 32'(rd_ovr), 1);
        chk("R3 newest data", 32'(rd_data[7:0]), 32'(8'(15 * 7 + 1)));
        take();
        @(negedge clk); #1;
        chk("R3 dropped char absent", 32'(rx_avail), 0);

        // R10: read while empty
        take();
        @(negedge clk); #1;
        chk("R10 empty read", 32'(rx_avail), 0);

        // R4: overrun pulse with a write, then on empty queue
        cyc(1, 8'h3C, 0, 0, 0, 0, 1, 0, 0, 0);
        @(negedge clk); #1;
        chk("R4 tag on written entry", 32'(rd_ovr), 1);
        take();
        cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
        put(8'h11, 0);
        @(negedge clk); #1;
        chk("R4 no tag from empty", 32'(rd_ovr), 0);
        take();

        // R8: flush with a write in the same cycle
        for (int i = 0; i < 5; i++) put(8'(i), 0);
        cyc(1, 8'h99, 0, 0, 0, 0, 0, 1, 1, 0);
        @(negedge clk); #1;
        chk("R8 flushed", 32'(rx_avail), 0);

        // R2: disabled queue behaves as one holding entry
        fifo_en = 0; ovr_irq_en = 0;
        put(8'hA1, 0);
        chk("R2 single full", 32'(rx_full), 1);
        put(8'hA2, 0);
        @(negedge clk); #1;
        chk("R2 holding data", 32'(rd_data), 32'h00A1);
        chk("R2 holding tagged", 32'(rd_ovr), 1);
        take();

        // R6: extended read
        fifo_en = 1; ext_read = 1;
        put(8'h55, 1); put(8'h66, 0);
        @(negedge clk); #1;
        chk("R6 ext upper bit", 32'(rd_data), 32'h0155);
        take();
        @(negedge clk); #1;
        chk("R6 stat set", 32'(stat_addr), 1);
        take();
        @(negedge clk); #1;
        chk("R6 stat follows", 32'(stat_addr), 0);

        // R7: non-extended sticky bit
        ext_read = 0;
        put(8'h77, 1); put(8'h78, 0);
        @(negedge clk); #1;
        chk("R7 no upper bit", 32'(rd_data), 32'h0077);
        take(); take();
        @(negedge clk); #1;
        chk("R7 sticky", 32'(stat_addr), 1);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        @(negedge clk); #1;
        chk("R7 cleared", 32'(stat_addr), 0);

        // random phases
        for (int seg = 0; seg < 4; seg++) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
            fifo_en = (seg != 2);
            ext_read = seg[0];
            ovr_irq_en = seg[1];
            for (int n = 0; n < 1500; n++) begin
                logic v, rd, ovp, clr;
                int pw;
                pw  = (n < 750) ? 70 : 30;
                v   = ($urandom % 100) < pw;
                rd  = ($urandom % 100) < (100 - pw);
                ovp = ($urandom % 100) < 4;
                clr = ($urandom % 100) < 5;
                if (ovp && rd) rd = 0;
                if (v && rd && q.size() >= cap_now()) rd = 0;
                cyc(v, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                    1'($urandom), ovp, rd, 0, clr);
            end
        end
        idle();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule